// File: doc/BRIEF.md
# Component Video Capture Demultiplexer

This block sits behind an 8-bit video capture port. The port carries 4:2:2 luma and colour-difference samples interleaved on one byte lane, with timing codes embedded in the stream. The block finds those codes and tracks which part of each line is active picture. It splits the active samples into three planar streams: luma (Y), blue difference (U) and red difference (V). Each plane has its own valid strobe, data byte and pixel index within the line. A memory writer can consume the planes directly and needs no software help for each pixel.

A control input selects 2:1 horizontal decimation. In that mode every other luma sample and every other colour-difference pair are kept, so the planes stay 4:2:2 and a 720-sample line becomes 360 samples. The selection is taken at the start of each line. A line counter and a field flag are shared by all three planes.

Top module: `vcap_demux`

## Requirements
- R1: While reset is held and after it is released, with no input seen yet, all three valid strobes are 0, all pixel indices are 0, `lineNum` is 0 and `fieldId` is 0.
- R2: A timing code is the bytes 0xFF, 0x00, 0x00 followed by a status byte. In the status byte, bit 4 is 1 for end of active video and 0 for start. Bit 5 is 1 during vertical blanking. Bit 6 is the field. A start code with bit 5 = 0 opens an active line.
- R3: In an active line the bytes arrive in the repeating order U, Y, V, Y. At full rate each byte raises the strobe of its own plane, and the data appears on that plane's data port one clock after the byte is sampled.
- R4: At full rate the Y pixel index counts 0, 1, 2, … through the line. The U and V indices equal the number of the U,Y,V,Y group, counted from 0.
- R5: With decimation, only the first Y of each group is output, with index equal to the group number. U and V are output only from even groups, with index equal to the group number divided by two. A line of 720 (640) luma samples yields 360 (320) Y and 180 (160) U and V samples.
- R6: `decimEn` is sampled with each start-of-active-video status byte. A change during the line has no effect until the next line.
- R7: The bytes of a timing code, the bytes after an end code, and the bytes after a start code with bit 5 = 1 raise no strobe.
- R8: `lineNum` advances by one on each end code that has bit 5 = 0. It clears to 0 on any status byte with bit 5 = 1. `fieldId` takes bit 6 of each start code.
- R9: At most one of the three valid strobes is high in any cycle.
- R10: The value 0xFF is reserved and never treated as a sample. An 0xFF that is not followed by 0x00, 0x00 ends the active line, and the following bytes raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| dIn | input | 8 | Multiplexed sample byte |
| decimEn | input | 1 | Requests 2:1 horizontal decimation, taken at line start |
| yValid | output | 1 | Luma sample strobe |
| yData | output | 8 | Luma sample |
| yPix | output | PIX_W | Luma pixel index within the line |
| uValid | output | 1 | Blue-difference strobe |
| uData | output | 8 | Blue-difference sample |
| uPix | output | PIX_W | Blue-difference index |
| vValid | output | 1 | Red-difference strobe |
| vData | output | 8 | Red-difference sample |
| vPix | output | PIX_W | Red-difference index |
| lineNum | output | LINE_W | Active line number within the field |
| fieldId | output | 1 | Field of the current line |

## Verification
A wrong phase counter shows up right away: a byte lands in the wrong plane on the first sample after the start code, or a strobe fires on the wrong byte. A wrong group counter or decimation latch shows up in the pixel indices within a few groups. It also makes the totals for a full line wrong, and those totals are checked at the 640 and 720 sizes. A code detector that stays stuck shows up as missing or extra strobes, or as a `lineNum` that fails to step or to clear once the next status byte arrives.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_FF, ST_Z1, ST_Z2} codeState_t;

  typedef struct packed {
    logic yStb;
    logic uStb;
    logic vStb;
    logic yLate;   // second luma of the group
    logic halve;   // decimated line
  } vcapStb_t;
endpackage

// File: rtl/vcap_ctrl.sv
module vcap_ctrl
  import vcap_pkg::*;
#(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        dIn,
  input  logic              decimEn,
  output vcapStb_t          stb,
  output logic [PIX_W-1:0]  pairIdx,
  output logic [LINE_W-1:0] lineCnt,
  output logic              fieldBit
);
  localparam logic [7:0] CODE_FF = 8'hFF;
  localparam logic [7:0] CODE_00 = 8'h00;

  codeState_t state;
  logic       active;
  logic       decimLine;
  logic [1:0] phase;
  logic       takeSample;
  logic       keepChroma;
  logic       statusByte;

  always_comb begin
    statusByte = (state == ST_Z2);
    takeSample = active && (state == ST_HUNT) && (dIn != CODE_FF);
    keepChroma = !decimLine || !pairIdx[0];
    stb.uStb   = takeSample && (phase == 2'd0) && keepChroma;
    stb.vStb   = takeSample && (phase == 2'd2) && keepChroma;
    stb.yStb   = takeSample && ((phase == 2'd1) || ((phase == 2'd3) && !decimLine));
    stb.yLate  = phase[1];
    stb.halve  = decimLine;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_HUNT;
      active    <= 1'b0;
      decimLine <= 1'b0;
      phase     <= 2'd0;
      pairIdx   <= '0;
      lineCnt   <= '0;
      fieldBit  <= 1'b0;
    end else begin
      if (dIn == CODE_FF) active <= 1'b0;
      case (state)
        ST_HUNT: if (dIn == CODE_FF) state <= ST_FF;
        ST_FF:   state <= (dIn == CODE_00) ? ST_Z1 : (dIn == CODE_FF) ? ST_FF : ST_HUNT;
        ST_Z1:   state <= (dIn == CODE_00) ? ST_Z2 : (dIn == CODE_FF) ? ST_FF : ST_HUNT;
        default: begin
          state <= ST_HUNT;
          if (!dIn[4]) begin
            active    <= !dIn[5];
            fieldBit  <= dIn[6];
            decimLine <= decimEn;
            phase     <= 2'd0;
            pairIdx   <= '0;
          end
          if (dIn[5])      lineCnt <= '0;
          else if (dIn[4]) lineCnt <= lineCnt + LINE_W'(1);
        end
      endcase
      if (takeSample) begin
        phase <= phase + 2'd1;
        if (phase == 2'd3) pairIdx <= pairIdx + PIX_W'(1);
      end
    end
  end

  // R6: decimation choice only moves on a start-of-line status byte
  a_r6_decim_held: assert property (@(posedge clk) disable iff (!rstN)
    !(statusByte && !dIn[4]) |=> $stable(decimLine));

  // R8: line counter only moves on a status byte
  a_r8_line_held: assert property (@(posedge clk) disable iff (!rstN)
    !statusByte |=> $stable(lineCnt));

  // R2: a start code restarts the group sequence
  a_r2_sav_restart: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte && !dIn[4]) |=> (phase == 2'd0 && pairIdx == '0));
endmodule

// File: rtl/vcap_datapath.sv
module vcap_datapath
  import vcap_pkg::*;
#(
  parameter int PIX_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       dIn,
  input  vcapStb_t         stb,
  input  logic [PIX_W-1:0] pairIdx,
  output logic             yValid,
  output logic [7:0]       yData,
  output logic [PIX_W-1:0] yPix,
  output logic             uValid,
  output logic [7:0]       uData,
  output logic [PIX_W-1:0] uPix,
  output logic             vValid,
  output logic [7:0]       vData,
  output logic [PIX_W-1:0] vPix
);
  logic [PIX_W-1:0] lumaIdx;
  logic [PIX_W-1:0] chromaIdx;

  always_comb begin
    lumaIdx   = stb.halve ? pairIdx : {pairIdx[PIX_W-2:0], stb.yLate};
    chromaIdx = stb.halve ? (pairIdx >> 1) : pairIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      yValid <= 1'b0; uValid <= 1'b0; vValid <= 1'b0;
      yData  <= '0;   uData  <= '0;   vData  <= '0;
      yPix   <= '0;   uPix   <= '0;   vPix   <= '0;
    end else begin
      yValid <= stb.yStb;
      uValid <= stb.uStb;
      vValid <= stb.vStb;
      if (stb.yStb) begin yData <= dIn; yPix <= lumaIdx;   end
      if (stb.uStb) begin uData <= dIn; uPix <= chromaIdx; end
      if (stb.vStb) begin vData <= dIn; vPix <= chromaIdx; end
    end
  end

  // R9: one plane per cycle
  a_r9_one_plane: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({yValid, uValid, vValid}));

  // R3: two luma samples are never adjacent bytes
  a_r3_luma_spacing: assert property (@(posedge clk) disable iff (!rstN)
    yValid |=> !yValid);

  // R3: a chroma byte is always followed by a non-chroma byte
  a_r3_chroma_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (uValid || vValid) |=> !(uValid || vValid));

  // R4: a red-difference sample shares the index of the preceding blue one
  a_r4_pair_index: assert property (@(posedge clk) disable iff (!rstN)
    (vValid && $past(yValid) && $past(uValid, 2)) |-> (vPix == uPix));
endmodule

// File: rtl/vcap_demux.sv
module vcap_demux
  import vcap_pkg::*;
#(
  parameter int PIX_W  = 11,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        dIn,
  input  logic              decimEn,
  output logic              yValid,
  output logic [7:0]        yData,
  output logic [PIX_W-1:0]  yPix,
  output logic              uValid,
  output logic [7:0]        uData,
  output logic [PIX_W-1:0]  uPix,
  output logic              vValid,
  output logic [7:0]        vData,
  output logic [PIX_W-1:0]  vPix,
  output logic [LINE_W-1:0] lineNum,
  output logic              fieldId
);
  vcapStb_t         stb;
  logic [PIX_W-1:0] pairIdx;

  vcap_ctrl #(.PIX_W(PIX_W), .LINE_W(LINE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .dIn(dIn), .decimEn(decimEn),
    .stb(stb), .pairIdx(pairIdx), .lineCnt(lineNum), .fieldBit(fieldId)
  );

  vcap_datapath #(.PIX_W(PIX_W)) dp_i (
    .clk(clk), .rstN(rstN), .dIn(dIn), .stb(stb), .pairIdx(pairIdx),
    .yValid(yValid), .yData(yData), .yPix(yPix),
    .uValid(uValid), .uData(uData), .uPix(uPix),
    .vValid(vValid), .vData(vData), .vPix(vPix)
  );
endmodule

// File: tb/vcap_demux_tb.sv
`timescale 1ns/100ps
module vcap_demux_tb_top;
  localparam int PIX_W  = 11;
  localparam int LINE_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] dIn = 8'h10;
  logic decimEn = 1'b0;
  logic yValid, uValid, vValid, fieldId;
  logic [7:0] yData, uData, vData;
  logic [PIX_W-1:0] yPix, uPix, vPix;
  logic [LINE_W-1:0] lineNum;

  int nChecks = 0;
  int nFails  = 0;
  int yCnt, uCnt, vCnt, lastY, lastU, lastV;

  always #2.5 clk = ~clk;

  vcap_demux #(.PIX_W(PIX_W), .LINE_W(LINE_W)) dut_i (.*);

  // {decim, byte, strobes y/u/v, index}
  localparam int NV = 36;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0,8'hFF,3'b000,11'd0}, {1'b0,8'h00,3'b000,11'd0}, {1'b0,8'h00,3'b000,11'd0}, {1'b0,8'h80,3'b000,11'd0},
    {1'b0,8'h11,3'b010,11'd0}, {1'b0,8'h21,3'b100,11'd0}, {1'b0,8'h31,3'b001,11'd0}, {1'b0,8'h22,3'b100,11'd1},
    {1'b0,8'h12,3'b010,11'd1}, {1'b0,8'h23,3'b100,11'd2}, {1'b0,8'h32,3'b001,11'd1}, {1'b0,8'h24,3'b100,11'd3},
    {1'b0,8'hFF,3'b000,11'd0}, {1'b0,8'h00,3'b000,11'd0}, {1'b0,8'h00,3'b000,11'd0}, {1'b0,8'h90,3'b000,11'd0},
    {1'b1,8'hFF,3'b000,11'd0}, {1'b1,8'h00,3'b000,11'd0}, {1'b1,8'h00,3'b000,11'd0}, {1'b1,8'h80,3'b000,11'd0},
    {1'b1,8'h41,3'b010,11'd0}, {1'b1,8'h51,3'b100,11'd0}, {1'b1,8'h61,3'b001,11'd0}, {1'b1,8'h52,3'b000,11'd0},
    {1'b1,8'h42,3'b000,11'd0}, {1'b1,8'h53,3'b100,11'd1}, {1'b1,8'h62,3'b000,11'd0}, {1'b1,8'h54,3'b000,11'd0},
    {1'b1,8'h43,3'b010,11'd1}, {1'b1,8'h55,3'b100,11'd2}, {1'b1,8'h63,3'b001,11'd1}, {1'b1,8'h56,3'b000,11'd0},
    {1'b1,8'hFF,3'b000,11'd0}, {1'b1,8'h00,3'b000,11'd0}, {1'b1,8'h00,3'b000,11'd0}, {1'b1,8'h90,3'b000,11'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic d);
    @(negedge clk);
    dIn = b;
    decimEn = d;
    @(posedge clk);
    #1;
    if (yValid) begin yCnt++; lastY = int'(yPix); end
    if (uValid) begin uCnt++; lastU = int'(uPix); end
    if (vValid) begin vCnt++; lastV = int'(vPix); end
  endtask

  task automatic sendCode(input logic [7:0] status, input logic d);
    sendByte(8'hFF, d);
    sendByte(8'h00, d);
    sendByte(8'h00, d);
    sendByte(status, d);
  endtask

  task automatic sendLine(input int nY, input logic [7:0] sav, input logic [7:0] eav,
                          input logic dSav, input logic dRun);
    sendCode(sav, dSav);
    yCnt = 0; uCnt = 0; vCnt = 0; lastY = -1; lastU = -1; lastV = -1;
    for (int p = 0; p < nY / 2; p++) begin
      sendByte(8'h10 + 8'(p % 64), dRun);
      sendByte(8'h60 + 8'(p % 32), dRun);
      sendByte(8'h90 + 8'(p % 64), dRun);
      sendByte(8'h70 + 8'(p % 32), dRun);
    end
    sendCode(eav, dRun);
  endtask

  initial begin
    #400000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: state during reset
    check(!yValid && !uValid && !vValid && yPix == 0 && uPix == 0 && vPix == 0
          && lineNum == 0 && !fieldId, "R1 reset", int'({yValid, uValid, vValid}), 0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check(!yValid && !uValid && !vValid && lineNum == 0, "R1 after release", int'(lineNum), 0);

    // R2 R3 R4 R5 R7: table walk
    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      bit ok;
      v = VEC[i];
      sendByte(v[21:14], v[22]);
      ok = ({yValid, uValid, vValid} == v[13:11]);
      if (v[13]) ok = ok && yData == v[21:14] && yPix == v[10:0];
      if (v[12]) ok = ok && uData == v[21:14] && uPix == v[10:0];
      if (v[11]) ok = ok && vData == v[21:14] && vPix == v[10:0];
      check(ok, "R3/R4/R5/R7 vector", i, int'(v[13:11]));
    end

    // R8: two active lines ended
    check(lineNum == 2, "R8 line count", int'(lineNum), 2);

    // R7 R8: blanking code clears line count, following bytes silent
    sendCode(8'hA0, 1'b0);
    check(lineNum == 0, "R8 clear on blanking", int'(lineNum), 0);
    yCnt = 0; uCnt = 0; vCnt = 0;
    for (int k = 0; k < 8; k++) sendByte(8'h20 + 8'(k), 1'b0);
    check(yCnt + uCnt + vCnt == 0, "R7 blanking bytes silent", yCnt + uCnt + vCnt, 0);

    // R10: stray 0xFF ends the line
    sendCode(8'h80, 1'b0);
    yCnt = 0; uCnt = 0; vCnt = 0;
    sendByte(8'h11, 1'b0);
    sendByte(8'h21, 1'b0);
    check(yCnt == 1 && uCnt == 1, "R10 samples before stray", yCnt + uCnt, 2);
    sendByte(8'hFF, 1'b0);
    yCnt = 0; uCnt = 0; vCnt = 0;
    for (int k = 0; k < 6; k++) sendByte(8'h55 + 8'(k), 1'b0);
    check(yCnt + uCnt + vCnt == 0, "R10 silent after stray", yCnt + uCnt + vCnt, 0);
    sendCode(8'h90, 1'b0);
    check(lineNum == 1, "R8 end code steps line", int'(lineNum), 1);

    // R8: field taken from start code
    sendLine(8, 8'hC0, 8'hD0, 1'b0, 1'b0);
    check(fieldId == 1'b1, "R8 field bit", int'(fieldId), 1);
    check(lineNum == 2, "R8 line after field-1 line", int'(lineNum), 2);

    // R3 R4: full-rate 720
    sendLine(720, 8'h80, 8'h90, 1'b0, 1'b0);
    check(yCnt == 720 && lastY == 719, "R4 full 720 luma", yCnt, 720);
    check(uCnt == 360 && vCnt == 360 && lastU == 359 && lastV == 359, "R4 full 720 chroma", uCnt, 360);
    check(fieldId == 1'b0, "R8 field back to 0", int'(fieldId), 0);

    // R5: decimated 720 and 640
    sendLine(720, 8'h80, 8'h90, 1'b1, 1'b1);
    check(yCnt == 360 && lastY == 359, "R5 720 to 360 luma", yCnt, 360);
    check(uCnt == 180 && vCnt == 180 && lastV == 179, "R5 720 chroma", uCnt, 180);
    sendLine(640, 8'h80, 8'h90, 1'b1, 1'b1);
    check(yCnt == 320 && lastY == 319, "R5 640 to 320 luma", yCnt, 320);
    check(uCnt == 160 && lastU == 159, "R5 640 chroma", uCnt, 160);

    // R6: mid-line change of decimEn ignored, both directions
    sendLine(16, 8'h80, 8'h90, 1'b0, 1'b1);
    check(yCnt == 16 && uCnt == 8, "R6 enable mid-line ignored", yCnt, 16);
    sendLine(16, 8'h80, 8'h90, 1'b1, 1'b0);
    check(yCnt == 8 && uCnt == 4, "R6 disable mid-line ignored", yCnt, 8);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule